// File: doc/BRIEF.md
# Data TLB translation unit

This block turns the virtual address of a data access into a physical address, or into a fault code paired with a memory-management status word. Each request carries a 64-bit virtual address, a store flag, a flag that bypasses translation entirely, a flag that marks the access as a page-table access, the current 2-bit privilege mode, an address-space number and a 2-bit superpage enable field. The page size is 8 KiB, so the page offset is 13 bits wide. The implemented virtual address is 43 bits and the physical address is 40 bits.

Addresses are handled in a fixed order. A bypassed access passes straight through. Any other address must first be sign-extended correctly. Next comes the kernel-only superpage window, which maps addresses directly. Everything else is looked up in a small fully associative table of page entries. A hit is then checked for read or write permission in the current mode, and for fault-on-read or fault-on-write. The table is filled through an insert port.

A two-state controller sequences each request. In IDLE a request strobe captures the result registers and moves the controller to RESP. In RESP the result is presented with `rsp_valid` high. From RESP a new strobe stays in RESP, and the absence of a strobe returns the controller to IDLE. The results are held until the next strobe.

Top module: `dtb_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0, `fault_code` is 0, `mm_status` is 0 and `pa` is 0. Every table entry is invalid, so any lookup misses.
- R2: Results appear with `rsp_valid`=1 in the cycle after a `req` strobe. `rsp_valid` is 0 in any cycle that does not follow a strobe. `fault_code`, `mm_status` and `pa` hold their values until the next strobe.
- R3: When `phys`=1, `pa` = `va[39:0]`, `fault_code`=0 (none) and `mm_status`=0, whatever the rest of the address holds.
- R4: When `phys`=0 and `va[63:42]` are not all equal, `fault_code`=2 (fault) and `mm_status` has ACV (bit 1) set, plus WR (bit 0) for a store. On every fault `pa`=0.
- R5: When `sp_en[1]`=1, `va[42:41]`=2'b10 and `mode`=0 (kernel), `pa` = `va[39:0]` with no table lookup and no fault.
- R6: The same superpage access with `mode`≠0 gives `fault_code`=1 (access violation) and `mm_status` = ACV, plus WR for a store. With `sp_en[1]`=0 the address goes to the table instead.
- R7: A table miss sets MISS (bit 4) in `mm_status`, plus WR for a store. `fault_code` is 3 when `pte_acc`=1 and 4 when `pte_acc`=0.
- R8: An entry hits only when both its page number (`va[42:13]`) and its address-space number match the request. On a hit `pa` = {entry frame number, `va[12:0]`}.
- R9: On a store hit, if write enable for the current mode is clear, `fault_code`=2 and `mm_status` = WR|ACV, plus FONW (bit 3) if the entry's fault-on-write bit is set. If write is enabled but fault-on-write is set, `fault_code`=2 and `mm_status` = WR|FONW.
- R10: On a load hit, if read enable for the current mode is clear, `fault_code`=1 and `mm_status` = ACV, plus FONR (bit 2) if the entry's fault-on-read bit is set. If read is enabled but fault-on-read is set, `fault_code`=2 and `mm_status` = FONR only.
- R11: When several entries match, the entry with the lowest index supplies the result.
- R12: An insert with `ins_en`=1 writes all fields of entry `ins_idx`, marks it valid and replaces any earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Translation request strobe |
| va | input | 64 | Virtual address |
| is_store | input | 1 | 1 for a store, 0 for a load |
| phys | input | 1 | Bypass translation |
| pte_acc | input | 1 | Access is a page-table access (selects miss code) |
| mode | input | 2 | Privilege mode, 0 = kernel |
| asn | input | 8 | Address-space number |
| sp_en | input | 2 | Superpage enable field; bit 1 enables the window |
| ins_en | input | 1 | Write one table entry |
| ins_idx | input | 3 | Entry index to write |
| ins_vpn | input | 30 | Virtual page number of the entry |
| ins_asn | input | 8 | Address-space number of the entry |
| ins_pfn | input | 27 | Physical frame number of the entry |
| ins_re | input | 4 | Read enable, one bit per mode |
| ins_we | input | 4 | Write enable, one bit per mode |
| ins_fonr | input | 1 | Fault-on-read bit |
| ins_fonw | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Result presented this cycle |
| fault_code | output | 3 | 0 none, 1 access violation, 2 fault, 3 page-table miss, 4 data miss |
| mm_status | output | 5 | bit0 WR, bit1 ACV, bit2 FONR, bit3 FONW, bit4 MISS |
| pa | output | 40 | Physical address, 0 on a fault |

## Verification
One group of inputs steps through the precedence chain. A bypassed address that is invalid shows that bypass comes before the validity check. Superpage addresses in kernel and user modes, and with the enable bit cleared, separate direct mapping, its access violation and the fall-through to the table. Table accesses use entries with mixed enable and fault-on bits and vary mode and direction, which tells each of the four permission outcomes apart. Duplicate page numbers under matching and non-matching address-space numbers show both the priority rule and the address-space qualification. An overwrite after insert and a lookup after a fresh reset show that entries are replaced and cleared.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

    typedef enum logic [2:0] {
        FC_NONE      = 3'd0,
        FC_ACV       = 3'd1,
        FC_FAULT     = 3'd2,
        FC_MISS_PT   = 3'd3,
        FC_MISS_DATA = 3'd4
    } fault_e;

    localparam int ST_W    = 5;
    localparam int ST_WR   = 0;
    localparam int ST_ACV  = 1;
    localparam int ST_FONR = 2;
    localparam int ST_FONW = 3;
    localparam int ST_MISS = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/dtb_entry_array.sv
module dtb_entry_array #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 30,
    parameter int ASN_W   = 8,
    parameter int PFN_W   = 27,
    parameter int MODES   = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_idx,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic [PFN_W-1:0] ins_pfn,
    input  logic [MODES-1:0] ins_re,
    input  logic [MODES-1:0] ins_we,
    input  logic             ins_fonr,
    input  logic             ins_fonw,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    output logic [MODES-1:0] hit_re,
    output logic [MODES-1:0] hit_we,
    output logic             hit_fonr,
    output logic             hit_fonw
);

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [ASN_W-1:0]   asn_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    logic [MODES-1:0]   re_q   [ENTRIES];
    logic [MODES-1:0]   we_q   [ENTRIES];
    logic [ENTRIES-1:0] fonr_q;
    logic [ENTRIES-1:0] fonw_q;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (ins_en) begin
            vld_q[ins_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            vpn_q[ins_idx]  <= ins_vpn;
            asn_q[ins_idx]  <= ins_asn;
            pfn_q[ins_idx]  <= ins_pfn;
            re_q[ins_idx]   <= ins_re;
            we_q[ins_idx]   <= ins_we;
            fonr_q[ins_idx] <= ins_fonr;
            fonw_q[ins_idx] <= ins_fonw;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn) && (asn_q[g] == lk_asn);
    end

    // lowest index wins: scan downward so the last assignment is the smallest
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                sel = IDX_W'(i);
            end
        end
    end

    assign hit_pfn  = pfn_q[sel];
    assign hit_re   = re_q[sel];
    assign hit_we   = we_q[sel];
    assign hit_fonr = fonr_q[sel];
    assign hit_fonw = fonw_q[sel];

    assert_insert_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> vld_q[$past(ins_idx)]);

    assert_hit_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q == '0) |-> !hit);

endmodule

// File: rtl/dtb_check.sv
module dtb_check
    import dtb_pkg::*;
#(
    parameter int VA_W   = 43,
    parameter int PA_W   = 40,
    parameter int OFS_W  = 13,
    parameter int MODES  = 4,
    localparam int PFN_W  = PA_W - OFS_W,
    localparam int MODE_W = $clog2(MODES)
) (
    input  logic [63:0]       va,
    input  logic              is_store,
    input  logic              phys,
    input  logic              pte_acc,
    input  logic [MODE_W-1:0] mode,
    input  logic [1:0]        sp_en,
    input  logic              hit,
    input  logic [PFN_W-1:0]  hit_pfn,
    input  logic [MODES-1:0]  hit_re,
    input  logic [MODES-1:0]  hit_we,
    input  logic              hit_fonr,
    input  logic              hit_fonw,
    output fault_e            code,
    output logic [ST_W-1:0]   status,
    output logic [PA_W-1:0]   pa
);

    logic va_ok;
    logic sp_win;

    assign va_ok  = (&va[63:VA_W-1]) || !(|va[63:VA_W-1]);
    assign sp_win = sp_en[1] && (va[VA_W-1:VA_W-2] == 2'b10);

    always_comb begin
        code   = FC_NONE;
        status = '0;
        pa     = '0;
        if (phys) begin
            pa = va[PA_W-1:0];
        end else if (!va_ok) begin
            code            = FC_FAULT;
            status[ST_ACV]  = 1'b1;
            status[ST_WR]   = is_store;
        end else if (sp_win) begin
            if (mode != '0) begin
                code           = FC_ACV;
                status[ST_ACV] = 1'b1;
                status[ST_WR]  = is_store;
            end else begin
                pa = va[PA_W-1:0];
            end
        end else if (!hit) begin
            code            = pte_acc ? FC_MISS_PT : FC_MISS_DATA;
            status[ST_MISS] = 1'b1;
            status[ST_WR]   = is_store;
        end else if (is_store) begin
            if (!hit_we[mode]) begin
                code            = FC_FAULT;
                status[ST_WR]   = 1'b1;
                status[ST_ACV]  = 1'b1;
                status[ST_FONW] = hit_fonw;
            end else if (hit_fonw) begin
                code            = FC_FAULT;
                status[ST_WR]   = 1'b1;
                status[ST_FONW] = 1'b1;
            end else begin
                pa = {hit_pfn, va[OFS_W-1:0]};
            end
        end else begin
            if (!hit_re[mode]) begin
                code            = FC_ACV;
                status[ST_ACV]  = 1'b1;
                status[ST_FONR] = hit_fonr;
            end else if (hit_fonr) begin
                code            = FC_FAULT;
                status[ST_FONR] = 1'b1;
            end else begin
                pa = {hit_pfn, va[OFS_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/dtb_xlate.sv
module dtb_xlate
    import dtb_pkg::*;
#(
    parameter int VA_W    = 43,
    parameter int PA_W    = 40,
    parameter int OFS_W   = 13,
    parameter int ENTRIES = 8,
    parameter int ASN_W   = 8,
    parameter int MODES   = 4,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int PFN_W  = PA_W - OFS_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int MODE_W = $clog2(MODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [63:0]       va,
    input  logic              is_store,
    input  logic              phys,
    input  logic              pte_acc,
    input  logic [MODE_W-1:0] mode,
    input  logic [ASN_W-1:0]  asn,
    input  logic [1:0]        sp_en,
    input  logic              ins_en,
    input  logic [IDX_W-1:0]  ins_idx,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic [PFN_W-1:0]  ins_pfn,
    input  logic [MODES-1:0]  ins_re,
    input  logic [MODES-1:0]  ins_we,
    input  logic              ins_fonr,
    input  logic              ins_fonw,
    output logic              rsp_valid,
    output logic [2:0]        fault_code,
    output logic [ST_W-1:0]   mm_status,
    output logic [PA_W-1:0]   pa
);

    ctl_state_e            state_q, state_d;
    fault_e                code_n, code_q;
    logic [ST_W-1:0]       status_n, status_q;
    logic [PA_W-1:0]       pa_n, pa_q;
    logic                  hit;
    logic [PFN_W-1:0]      hit_pfn;
    logic [MODES-1:0]      hit_re, hit_we;
    logic                  hit_fonr, hit_fonw;

    dtb_entry_array #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W),
        .PFN_W(PFN_W), .MODES(MODES)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .ins_en(ins_en), .ins_idx(ins_idx), .ins_vpn(ins_vpn),
        .ins_asn(ins_asn), .ins_pfn(ins_pfn), .ins_re(ins_re),
        .ins_we(ins_we), .ins_fonr(ins_fonr), .ins_fonw(ins_fonw),
        .lk_vpn(va[VA_W-1:OFS_W]), .lk_asn(asn),
        .hit(hit), .hit_pfn(hit_pfn), .hit_re(hit_re), .hit_we(hit_we),
        .hit_fonr(hit_fonr), .hit_fonw(hit_fonw)
    );

    dtb_check #(
        .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .MODES(MODES)
    ) u_check (
        .va(va), .is_store(is_store), .phys(phys), .pte_acc(pte_acc),
        .mode(mode), .sp_en(sp_en), .hit(hit), .hit_pfn(hit_pfn),
        .hit_re(hit_re), .hit_we(hit_we), .hit_fonr(hit_fonr),
        .hit_fonw(hit_fonw), .code(code_n), .status(status_n), .pa(pa_n)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)  state_d = ST_RESP;
            ST_RESP: if (!req) state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= FC_NONE;
            status_q <= '0;
            pa_q     <= '0;
        end else if (req) begin
            code_q   <= code_n;
            status_q <= status_n;
            pa_q     <= pa_n;
        end
    end

    assign rsp_valid  = (state_q == ST_RESP);
    assign fault_code = code_q;
    assign mm_status  = status_q;
    assign pa         = pa_q;

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);

    assert_no_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);

    assert_hold_results_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(fault_code) && $stable(mm_status) && $stable(pa)));

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && phys) |=> (fault_code == 3'd0 && mm_status == '0 &&
                           pa == $past(va[PA_W-1:0])));

    assert_superpage_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !phys && sp_en[1] && (&va[63:VA_W-1]) && !va[VA_W-2] && mode != '0)
        |=> (fault_code == 3'd1));

    assert_fault_clears_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 3'd0) |-> (pa == '0));

endmodule

// File: tb/dtb_xlate_tb.sv
module dtb_xlate_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    typedef struct packed {
        logic [63:0] va;
        logic        wr;
        logic        phys;
        logic        pte;
        logic [1:0]  mode;
        logic [7:0]  asn;
        logic [1:0]  sp;
        logic [2:0]  code;
        logic [4:0]  st;
        logic [39:0] pa;
        logic [3:0]  rq;
    } vec_t;

    // va, wr, phys, pte, mode, asn, sp, code, status, pa, requirement
    localparam vec_t VECS [NV] = '{
        '{64'hFFFF_0000_1234_5678, 1'b0, 1'b1, 1'b0, 2'd0, 8'd5, 2'b10, 3'd0, 5'h00, 40'h00_1234_5678, 4'd3},  // R3
        '{64'h0000_1000_0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5, 2'b10, 3'd2, 5'h02, 40'h0,            4'd4},  // R4
        '{64'h0000_1000_0000_0000, 1'b1, 1'b0, 1'b0, 2'd0, 8'd5, 2'b10, 3'd2, 5'h03, 40'h0,            4'd4},  // R4
        '{64'hFFFF_FD12_3456_789A, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5, 2'b10, 3'd0, 5'h00, 40'h12_3456_789A, 4'd5},  // R5
        '{64'hFFFF_FD12_3456_789A, 1'b0, 1'b0, 1'b0, 2'd3, 8'd5, 2'b10, 3'd1, 5'h02, 40'h0,            4'd6},  // R6
        '{64'hFFFF_FD12_3456_789A, 1'b1, 1'b0, 1'b0, 2'd1, 8'd5, 2'b11, 3'd1, 5'h03, 40'h0,            4'd6},  // R6
        '{64'hFFFF_FD12_3456_789A, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5, 2'b01, 3'd4, 5'h10, 40'h0,            4'd6},  // R6 window off -> miss
        '{64'h0000_0000_0008_0000, 1'b1, 1'b0, 1'b1, 2'd0, 8'd5, 2'b00, 3'd3, 5'h11, 40'h0,            4'd7},  // R7
        '{64'h0000_0000_0002_0123, 1'b0, 1'b0, 1'b0, 2'd2, 8'd5, 2'b00, 3'd0, 5'h00, 40'h00_0157_8123, 4'd8},  // R8
        '{64'h0000_0000_0002_1FFF, 1'b1, 1'b0, 1'b0, 2'd0, 8'd5, 2'b00, 3'd0, 5'h00, 40'h00_0157_9FFF, 4'd11}, // R11 entry0 over entry3
        '{64'h0000_0000_0002_0000, 1'b0, 1'b0, 1'b0, 2'd0, 8'd6, 2'b00, 3'd0, 5'h00, 40'h00_0133_2000, 4'd8},  // R8 asn 6
        '{64'h0000_0000_0002_0000, 1'b0, 1'b0, 1'b0, 2'd0, 8'd7, 2'b00, 3'd4, 5'h10, 40'h0,            4'd8},  // R8 asn mismatch
        '{64'h0000_0000_0002_0000, 1'b1, 1'b0, 1'b0, 2'd1, 8'd5, 2'b00, 3'd2, 5'h03, 40'h0,            4'd9},  // R9
        '{64'h0000_0000_0004_0000, 1'b1, 1'b0, 1'b0, 2'd0, 8'd5, 2'b00, 3'd2, 5'h0B, 40'h0,            4'd9},  // R9
        '{64'h0000_0000_0006_0000, 1'b1, 1'b0, 1'b0, 2'd3, 8'd5, 2'b00, 3'd2, 5'h09, 40'h0,            4'd9},  // R9
        '{64'h0000_0000_0004_0000, 1'b0, 1'b0, 1'b0, 2'd2, 8'd5, 2'b00, 3'd1, 5'h06, 40'h0,            4'd10}, // R10
        '{64'h0000_0000_0004_0000, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5, 2'b00, 3'd2, 5'h04, 40'h0,            4'd10}, // R10
        '{64'h0000_0000_0002_0000, 1'b0, 1'b0, 1'b0, 2'd1, 8'd5, 2'b00, 3'd0, 5'h00, 40'h00_0157_8000, 4'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [63:0] va = '0;
    logic        is_store = 1'b0;
    logic        phys = 1'b0;
    logic        pte_acc = 1'b0;
    logic [1:0]  mode = '0;
    logic [7:0]  asn = '0;
    logic [1:0]  sp_en = '0;
    logic        ins_en = 1'b0;
    logic [2:0]  ins_idx = '0;
    logic [29:0] ins_vpn = '0;
    logic [7:0]  ins_asn = '0;
    logic [26:0] ins_pfn = '0;
    logic [3:0]  ins_re = '0;
    logic [3:0]  ins_we = '0;
    logic        ins_fonr = 1'b0;
    logic        ins_fonw = 1'b0;
    logic        rsp_valid;
    logic [2:0]  fault_code;
    logic [4:0]  mm_status;
    logic [39:0] pa;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtb_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .va(va), .is_store(is_store),
        .phys(phys), .pte_acc(pte_acc), .mode(mode), .asn(asn), .sp_en(sp_en),
        .ins_en(ins_en), .ins_idx(ins_idx), .ins_vpn(ins_vpn), .ins_asn(ins_asn),
        .ins_pfn(ins_pfn), .ins_re(ins_re), .ins_we(ins_we),
        .ins_fonr(ins_fonr), .ins_fonw(ins_fonw),
        .rsp_valid(rsp_valid), .fault_code(fault_code),
        .mm_status(mm_status), .pa(pa)
    );

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic insert(input logic [2:0] idx, input logic [29:0] vpn,
                          input logic [7:0] a, input logic [26:0] pfn,
                          input logic [3:0] re, input logic [3:0] we,
                          input logic fr, input logic fw);
        @(negedge clk);
        ins_en = 1'b1; ins_idx = idx; ins_vpn = vpn; ins_asn = a;
        ins_pfn = pfn; ins_re = re; ins_we = we; ins_fonr = fr; ins_fonw = fw;
        @(negedge clk);
        ins_en = 1'b0;
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        req = 1'b1; va = v.va; is_store = v.wr; phys = v.phys;
        pte_acc = v.pte; mode = v.mode; asn = v.asn; sp_en = v.sp;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        check("R1", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R1", "fault_code", {61'd0, fault_code}, 64'd0);
        check("R1", "mm_status", {59'd0, mm_status}, 64'd0);
        check("R1", "pa", {24'd0, pa}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        insert(3'd0, 30'h10, 8'd5, 27'hABC,  4'b1111, 4'b0001, 1'b0, 1'b0);
        insert(3'd1, 30'h20, 8'd5, 27'h1234, 4'b0001, 4'b0000, 1'b1, 1'b1);
        insert(3'd2, 30'h30, 8'd5, 27'h55,   4'b1111, 4'b1111, 1'b1, 1'b1);
        insert(3'd3, 30'h10, 8'd5, 27'h7777, 4'b1111, 4'b1111, 1'b0, 1'b0);
        insert(3'd4, 30'h10, 8'd6, 27'h999,  4'b1111, 4'b1111, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d[v%0d]", VECS[i].rq, i);
            issue(VECS[i]);
            check(rq, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
            check(rq, "fault_code", {61'd0, fault_code}, {61'd0, VECS[i].code});
            check(rq, "mm_status", {59'd0, mm_status}, {59'd0, VECS[i].st});
            check(rq, "pa", {24'd0, pa}, {24'd0, VECS[i].pa});
        end

        // R2: results held, valid drops, while inputs wander without a strobe
        va = 64'h0000_0000_0004_0000; is_store = 1'b1; mode = 2'd3;
        @(negedge clk);
        check("R2", "rsp_valid low", {63'd0, rsp_valid}, 64'd0);
        repeat (2) @(negedge clk);
        check("R2", "pa held", {24'd0, pa}, 64'h0157_8000);
        check("R2", "code held", {61'd0, fault_code}, 64'd0);

        // R12: overwrite entry 0 with a new frame
        insert(3'd0, 30'h10, 8'd5, 27'hDEF, 4'b1111, 4'b1111, 1'b0, 1'b0);
        issue('{64'h0000_0000_0002_0000, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5, 2'b00,
                3'd0, 5'h00, 40'h00_01BD_E000, 4'd12});
        check("R12", "pa after overwrite", {24'd0, pa}, 64'h01BD_E000);
        check("R12", "code after overwrite", {61'd0, fault_code}, 64'd0);

        // R1: a fresh reset invalidates every entry
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        issue('{64'h0000_0000_0002_0000, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5, 2'b00,
                3'd4, 5'h10, 40'h0, 4'd1});
        check("R1", "miss after reset code", {61'd0, fault_code}, 64'd4);
        check("R1", "miss after reset status", {59'd0, mm_status}, 64'h10);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule